// File: doc/BRIEF.md
# Serial-Programmed Wiper Position Register

This block is the digital control core of a 128-position digital potentiometer. A three-wire serial port shifts a 7-bit position code into a shift register. The port has an active-low select, a serial clock and serial data in. When the select line returns high, the code is committed to a wiper latch. The latch output drives the decoder of an external resistor ladder. Two more control inputs act on the latch and the switches. A preset input, active low, forces the latch to midscale. A sleep input, active low, opens the top-terminal switch and shorts the wiper to the bottom terminal, and the stored code is kept.

The serial pins are asynchronous to the block. They are sampled by a system clock that runs at least 8 times faster than the serial clock, through two-flop synchronizers, and their edges are detected in that clock domain. Every shift pushes the oldest bit of the shift register into an open-drain output stage. A frame therefore reappears at the output one frame later, so several devices can share one select line in a chain. The block has no streaming data path, so all pins are plain control and status levels with no valid/ready handshake.

Top module: `wiper_code_ctrl`

## Requirements
- R1: A frame is a low period of `ser_sel_n`. Bits are sampled on rising edges of `ser_clk` and loaded MSB first. When `ser_sel_n` rises, `wiper_code` takes the last 7 bits; the first of them lands in bit 6.
- R2: If a frame has more than 7 clocks, the earlier bits are dropped and only the final 7 reach `wiper_code`.
- R3: Rising edges of `ser_clk` while `ser_sel_n` is high do not change `wiper_code` or the shift register. A following frame with no clocks loads the unchanged register content.
- R4: `wiper_code` holds its value during a frame and changes only when `ser_sel_n` rises.
- R5: After each shift, `dout_pull_low` is 1 exactly when the bit shifted in 7 shifts earlier was 0. With 14 clocks in one frame, the first 7 bits leave on the output during the second 7 shifts.
- R6: While `preset_n` is low, `wiper_code` is 0x40 and `dout_pull_low` is 0.
- R7: A `ser_sel_n` rise that reaches the block in the same cycle as a `preset_n` fall loads nothing. The code stays 0x40 after the preset is released.
- R8: While `sleep_n` is low, `top_sw_en` is 0, `wiper_to_bottom` is 1 and `dout_pull_low` is 0, and `wiper_code` keeps its value. After release, `top_sw_en` is 1 and `wiper_to_bottom` is 0 again.
- R9: Frames sent while `sleep_n` is low still load `wiper_code`, and the new code stays in effect after release.
- R10: After system reset, `wiper_code` is 0x40, `top_sw_en` is 1, `wiper_to_bottom` is 0 and `dout_pull_low` is 0. The shift register holds zeros.
- R11: A change on a serial or control pin shows at the outputs within 4 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| ser_sel_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial clock, rising edge samples data |
| ser_din | input | 1 | Serial data in, MSB first |
| preset_n | input | 1 | Midscale preset, active low |
| sleep_n | input | 1 | Shutdown, active low |
| wiper_code | output | 7 | Latched wiper position code |
| top_sw_en | output | 1 | Top-terminal switch closed when 1 |
| wiper_to_bottom | output | 1 | Wiper shorted to bottom terminal when 1 |
| dout_pull_low | output | 1 | Open-drain data out: 1 pulls low, 0 releases |

## Verification
The hardest case to reach from the ports is the preset arriving in the very system cycle in which a select rise is detected. This case only occurs because both pins pass through matching synchronizers. The bench changes `preset_n` and `ser_sel_n` on the same falling edge of the system clock, so both reach the detector in the same cycle. It then releases the preset and checks that no deferred load appears. The output stage has a similar issue: its state carries across frames. So the bench keeps a running 7-bit model through random-length frames and through the 14-clock chain frame.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef struct packed {
    logic sel_n;
    logic sclk;
    logic din;
    logic preset_n;
    logic sleep_n;
  } pin_t;

  localparam pin_t PIN_IDLE = '{sel_n: 1'b1, sclk: 1'b0, din: 1'b0,
                                preset_n: 1'b1, sleep_n: 1'b1};
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/shift_path.sv
module shift_path #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              clr,
  output logic [CODE_W-1:0] sr,
  output logic              pull_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (shift_en) begin
      sr <= {sr[CODE_W-2:0], bit_in};
    end
  end

  // output stage holds the pull-down request for the bit leaving the register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= 1'b0;
    end else if (clr) begin
      pull_q <= 1'b0;
    end else if (shift_en) begin
      pull_q <= ~sr[CODE_W-1];
    end
  end

  assert_sr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr));
  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr[0] == $past(bit_in));
  assert_out_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> pull_q == !$past(sr[CODE_W-1]));
  assert_out_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pull_q);
endmodule

// File: rtl/code_latch.sv
module code_latch #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              preset,
  input  logic [CODE_W-1:0] sr,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= MID;
    end else if (preset) begin
      code <= MID;
    end else if (load) begin
      code <= sr;
    end
  end

  assert_preset_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> code == MID);
  assert_load_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !preset) |=> code == $past(sr));
  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !preset) |=> $stable(code));
endmodule

// File: rtl/wiper_code_ctrl.sv
module wiper_code_ctrl #(
  parameter int CODE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              preset_n,
  input  logic              sleep_n,
  output logic [CODE_W-1:0] wiper_code,
  output logic              top_sw_en,
  output logic              wiper_to_bottom,
  output logic              dout_pull_low
);
  import wiper_pkg::*;

  localparam int PIN_W = $bits(pin_t);

  pin_t pins_raw, pins_s;
  logic sclk_d, sel_d;
  logic sclk_rise, sel_rise, shift_en;
  logic [CODE_W-1:0] sr;
  logic pull_q;

  assign pins_raw = '{sel_n: ser_sel_n, sclk: ser_clk, din: ser_din,
                      preset_n: preset_n, sleep_n: sleep_n};

  pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pins_raw),
    .sync_out (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= PIN_IDLE.sclk;
      sel_d  <= PIN_IDLE.sel_n;
    end else begin
      sclk_d <= pins_s.sclk;
      sel_d  <= pins_s.sel_n;
    end
  end

  assign sclk_rise = pins_s.sclk & ~sclk_d;
  assign sel_rise  = pins_s.sel_n & ~sel_d;
  assign shift_en  = ~pins_s.sel_n & sclk_rise;

  shift_path #(.CODE_W(CODE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .bit_in   (pins_s.din),
    .clr      (~pins_s.preset_n),
    .sr       (sr),
    .pull_q   (pull_q)
  );

  code_latch #(.CODE_W(CODE_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (sel_rise),
    .preset (~pins_s.preset_n),
    .sr     (sr),
    .code   (wiper_code)
  );

  assign top_sw_en       = pins_s.sleep_n;
  assign wiper_to_bottom = ~pins_s.sleep_n;
  assign dout_pull_low   = pull_q & pins_s.sleep_n;

  assert_frame_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_d && pins_s.sel_n) |=> $stable(sr));
endmodule

// File: tb/wiper_code_ctrl_tb.sv
module wiper_code_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic preset_n = 1'b1, sleep_n = 1'b1;
  logic [6:0] wiper_code;
  logic top_sw_en, wiper_to_bottom, dout_pull_low;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [6:0] sr_m = '0;
  logic       pull_m = 1'b0;
  logic       sleeping = 1'b0;
  logic [6:0] code_m = 7'h40;
  logic [6:0] obs = '0;

  always #5 clk = ~clk;

  wiper_code_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .preset_n(preset_n), .sleep_n(sleep_n),
    .wiper_code(wiper_code), .top_sw_en(top_sw_en),
    .wiper_to_bottom(wiper_to_bottom), .dout_pull_low(dout_pull_low)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_din = b;
    wait_n(4);
    ser_clk = 1'b1;
    pull_m = ~sr_m[6];
    sr_m = {sr_m[5:0], b};
    wait_n(4);
    chk("R5 data out after shift", dout_pull_low, pull_m & ~sleeping);
    obs = {obs[5:0], ~dout_pull_low};
    ser_clk = 1'b0;
    wait_n(4);
  endtask

  task automatic run_frame(input int n, input logic [15:0] data);
    ser_sel_n = 1'b0;
    wait_n(4);
    for (int i = n - 1; i >= 0; i--) shift_bit(data[i]);
    chk("R4 code held during frame", wiper_code, code_m);
    ser_sel_n = 1'b1;
    code_m = sr_m;
    wait_n(4);
    chk(n > 7 ? "R2 last seven bits kept, R11" : "R1 frame load, R11",
        wiper_code, code_m);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R10 reset code", wiper_code, 7'h40);
    chk("R10 reset top switch", top_sw_en, 1);
    chk("R10 reset wiper short", wiper_to_bottom, 0);
    chk("R10 reset data out", dout_pull_low, 0);

    run_frame(7, 16'h0055);
    run_frame(7, 16'h007F);
    run_frame(7, 16'h0000);
    run_frame(9, 16'h0103);

    // R5: 14-clock chain frame, first seven bits leave on data out
    run_frame(14, 16'h2A5C);
    chk("R5 chain forwards first seven bits", obs, 7'h54);

    // R3: clocks with select high are ignored
    for (int i = 0; i < 5; i++) begin
      ser_din = 1'($urandom);
      wait_n(4); ser_clk = 1'b1; wait_n(4); ser_clk = 1'b0; wait_n(4);
    end
    chk("R3 code unchanged by idle clocks", wiper_code, code_m);
    run_frame(0, 16'h0000);
    chk("R3 shift register unchanged by idle clocks", wiper_code, 7'h5C);

    // R6 and R7: preset together with a select rise
    ser_sel_n = 1'b0; wait_n(4);
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b1);
    @(negedge clk);
    ser_sel_n = 1'b1;
    preset_n = 1'b0;
    pull_m = 1'b0;
    code_m = 7'h40;
    wait_n(4);
    chk("R7 preset wins over load", wiper_code, 7'h40);
    chk("R6 preset clears data out", dout_pull_low, 0);
    wait_n(3);
    preset_n = 1'b1;
    wait_n(5);
    chk("R7 no deferred load after preset", wiper_code, 7'h40);
    chk("R6 data out stays released", dout_pull_low, 0);

    run_frame(7, 16'h0011);

    // R8 and R9: shutdown keeps code, still accepts frames
    sleep_n = 1'b0; sleeping = 1'b1;
    wait_n(4);
    chk("R8 sleep opens top switch", top_sw_en, 0);
    chk("R8 sleep shorts wiper", wiper_to_bottom, 1);
    chk("R8 sleep keeps code", wiper_code, 7'h11);
    run_frame(7, 16'h0026);
    chk("R9 program during sleep", wiper_code, 7'h26);
    sleep_n = 1'b1; sleeping = 1'b0;
    wait_n(4);
    chk("R8 release closes top switch", top_sw_en, 1);
    chk("R8 release drops short", wiper_to_bottom, 0);
    chk("R9 preset code after release", wiper_code, 7'h26);
    chk("R8 data out driver restored", dout_pull_low, pull_m);

    // random frames of varying length
    for (int f = 0; f < 30; f++) begin
      int n = 7 + int'($urandom_range(9));
      run_frame(n, 16'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule